// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits between a memory controller's command scheduler and the pins of a mobile SDRAM. It owns the clock-enable line and the command bus. While the memory is in normal operation, it passes the scheduler's commands through one register stage. When a low-power request is granted, it replaces them with the CKE transition and command code that move the memory into power-down, self refresh, deep power-down or clock suspend. Later it brings the memory back out and holds off new traffic until the exit timing is met.

A shadow of the memory's state is rebuilt from the pins alone. On every edge the tracker takes the CKE level seen at the previous edge, the CKE level at the present edge and the command on the bus, and derives the state the memory enters. Each low-power mode is requested through its own four-phase request/acknowledge pair: the request is held high to stay in the mode and dropped to leave it. After a self-refresh exit the bus carries only NOPs for a parameterised window, and that window must contain a minimum number of NOPs. After a deep power-down exit the block raises a flag that asks the controller to re-run the initialisation sequence. The block does not return to normal operation until that sequence reports completion.

Top module: `lp_cke_seq`

## Requirements
- R1: After reset, sdr_cke is high, sdr_cmd is NOP (4'b0111, bit order {cs_n,ras_n,cas_n,we_n}), mem_state is 0 (normal), and every acknowledge and init_req is low.
- R2: In normal operation with no granted request, host_ready is high, and host_cmd appears on sdr_cmd at the next clock with sdr_cke high.
- R3: A granted power-down request drives sdr_cke low with NOP on the next clock, and mem_state becomes 1 with pd_ack high two clocks after the request.
- R4: A granted self-refresh request drives sdr_cke low with AUTO REFRESH (4'b0001), and mem_state becomes 2 with sr_ack high.
- R5: A granted deep power-down request drives sdr_cke low with the burst-terminate code (4'b0110), and mem_state becomes 3 with dpd_ack high.
- R6: While the memory is in power-down, self refresh, deep power-down or clock suspend and the request stays high, sdr_cke stays low, host_cmd is ignored (sdr_cmd holds NOP) and host_ready is low.
- R7: Dropping pd_req raises sdr_cke with NOP. The memory is then back in normal operation (mem_state 0), and host_ready returns three clocks after the drop.
- R8: Dropping sr_req raises sdr_cke and moves mem_state to 5 (self-refresh exit). The bus then carries only NOP or INHIBIT until XSR_CYC edges have passed and at least MIN_NOPS NOPs were issued. With the defaults, host_ready returns XSR_CYC+4 clocks after the drop.
- R9: Dropping dpd_req raises sdr_cke and sets mem_state 6 with init_req high two clocks after the drop. Host commands pass through while init_req is high. A one-clock init_done pulse returns mem_state to 0 and clears init_req at the next clock.
- R10: cs_req granted during a transfer (xfer_active high) drops sdr_cke with NOP, and mem_state becomes 4 with cs_ack high. Dropping cs_req raises sdr_cke again.
- R11: Only one mode is entered at a time, with the fixed priority clock suspend, then deep power-down, then self refresh, then power-down. A losing request stays pending and is granted once normal operation resumes.
- R12: Power-down, self refresh and deep power-down are entered only while banks_idle is high and xfer_active is low. Otherwise the request is held, and pass-through continues.
- R13: The block never puts an illegal combination of state, CKE pair and command on the pins, and mem_state always matches the state a pin-level memory model reaches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks precharged, no bank open |
| xfer_active | input | 1 | A read or write burst is in progress |
| host_cmd | input | 4 | Scheduler command {cs_n,ras_n,cas_n,we_n} |
| host_ready | output | 1 | host_cmd is taken this clock |
| pd_req | input | 1 | Power-down request (held) |
| pd_ack | output | 1 | Memory is in power-down |
| sr_req | input | 1 | Self-refresh request (held) |
| sr_ack | output | 1 | Memory is in self refresh or its exit window |
| dpd_req | input | 1 | Deep power-down request (held) |
| dpd_ack | output | 1 | Memory is in deep power-down |
| cs_req | input | 1 | Clock-suspend request (held) |
| cs_ack | output | 1 | Memory is in clock suspend |
| init_req | output | 1 | Re-initialisation needed after deep power-down |
| init_done | input | 1 | Pulse: re-initialisation finished |
| sdr_cke | output | 1 | Clock-enable pin |
| sdr_cmd | output | 4 | Command pins {cs_n,ras_n,cas_n,we_n} |
| mem_state | output | 3 | Shadow state: 0 normal, 1 PD, 2 SR, 3 DPD, 4 suspend, 5 SR exit, 6 uninit |

## Verification
Each mode is entered and left alone first. This separates the four entry codes from one another, and the self-refresh exit window from the one-clock power-down exit. Requests are then raised together (self refresh with power-down, deep power-down with self refresh) to show the priority order and that the loser stays pending. A power-down request raised while banks are open, and another raised during a transfer alongside clock suspend, show that the idle and transfer qualifiers gate entry. A pin-level memory model follows the bus on every clock, so any illegal CKE/command pair, a short exit window or a shadow state that drifts from the model is reported at once.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_AREF = 4'b0001;
    localparam logic [3:0] CMD_BST  = 4'b0110;

    typedef enum logic [2:0] {
        MS_NORMAL = 3'd0,
        MS_PD     = 3'd1,
        MS_SR     = 3'd2,
        MS_DPD    = 3'd3,
        MS_CSUSP  = 3'd4,
        MS_SRX    = 3'd5,
        MS_UNINIT = 3'd6
    } mstate_e;

    typedef enum logic [2:0] {
        LP_NONE = 3'd0,
        LP_CS   = 3'd1,
        LP_DPD  = 3'd2,
        LP_SR   = 3'd3,
        LP_PD   = 3'd4
    } lp_kind_e;

    typedef enum logic [2:0] {
        C_RUN, C_PD, C_SR, C_DPD, C_CS, C_WAIT, C_INIT
    } ctl_e;

    typedef struct packed {
        logic       cke;
        logic [3:0] cmd;
        logic       idle;
        logic       xfer;
    } pin_s;

    function automatic logic cmd_quiet(input logic [3:0] c);
        return c[3] || (c == CMD_NOP);
    endfunction

endpackage

// File: rtl/lp_arb.sv
module lp_arb
    import lp_pkg::*;
#(
    parameter int N_LP = 4
) (
    input  logic            en,
    input  logic            banks_idle,
    input  logic            xfer_active,
    input  logic [N_LP-1:0] req_vec,
    output lp_kind_e        grant
);

    logic [N_LP-1:0] qual;

    // index 0 is clock suspend (needs a transfer), the rest need idle banks
    for (genvar gi = 0; gi < N_LP; gi++) begin : g_qual
        if (gi == 0) begin : g_cs
            assign qual[gi] = en & req_vec[gi] & xfer_active;
        end else begin : g_idle
            assign qual[gi] = en & req_vec[gi] & banks_idle & ~xfer_active;
        end
    end

    always_comb begin
        grant = LP_NONE;
        for (int i = N_LP - 1; i >= 0; i--) begin
            if (qual[i]) grant = lp_kind_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/lp_shadow.sv
module lp_shadow
    import lp_pkg::*;
#(
    parameter int XSR_CYC  = 8,
    parameter int MIN_NOPS = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  pin_s    pins,
    input  logic    init_done,
    output mstate_e state,
    output logic    illegal
);

    localparam int CNT_W = $clog2(XSR_CYC + 1);
    localparam int NOP_W = $clog2(MIN_NOPS + 1);

    typedef struct packed {
        mstate_e          state;
        logic             cke_prev;
        logic [CNT_W-1:0] cnt;
        logic [NOP_W-1:0] nops;
    } shd_s;

    shd_s r_q, r_d;
    logic quiet;
    logic ill_d;

    always_comb begin
        r_d          = r_q;
        ill_d        = 1'b0;
        quiet        = cmd_quiet(pins.cmd);
        r_d.cke_prev = pins.cke;
        case (r_q.state)
            MS_NORMAL: begin
                if (!r_q.cke_prev) begin
                    ill_d = 1'b1;
                end else if (!pins.cke) begin
                    if (quiet && pins.xfer)
                        r_d.state = MS_CSUSP;
                    else if (quiet && pins.idle)
                        r_d.state = MS_PD;
                    else if (pins.cmd == CMD_AREF && pins.idle && !pins.xfer)
                        r_d.state = MS_SR;
                    else if (pins.cmd == CMD_BST && pins.idle && !pins.xfer)
                        r_d.state = MS_DPD;
                    else
                        ill_d = 1'b1;
                end
            end
            MS_PD, MS_SR, MS_DPD, MS_CSUSP: begin
                if (pins.cke) begin
                    if (!quiet) begin
                        ill_d = 1'b1;
                    end else begin
                        case (r_q.state)
                            MS_PD:  r_d.state = MS_NORMAL;
                            MS_SR: begin
                                r_d.state = MS_SRX;
                                r_d.cnt   = CNT_W'(XSR_CYC);
                                r_d.nops  = '0;
                            end
                            MS_DPD: r_d.state = MS_UNINIT;
                            default: r_d.state = MS_NORMAL;
                        endcase
                    end
                end
            end
            MS_SRX: begin
                if (!pins.cke || !quiet) begin
                    ill_d = 1'b1;
                end else if (r_q.cnt == '0 && r_q.nops >= NOP_W'(MIN_NOPS)) begin
                    r_d.state = MS_NORMAL;
                end else begin
                    if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
                    if (pins.cmd == CMD_NOP && r_q.nops < NOP_W'(MIN_NOPS))
                        r_d.nops = r_q.nops + 1'b1;
                end
            end
            MS_UNINIT: begin
                if (!pins.cke) ill_d = 1'b1;
                else if (init_done) r_d.state = MS_NORMAL;
            end
            default: ill_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= MS_NORMAL;
            r_q.cke_prev <= 1'b1;
            r_q.cnt      <= '0;
            r_q.nops     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.state;
    assign illegal = ill_d;

endmodule

// File: rtl/lp_cke_seq.sv
module lp_cke_seq
    import lp_pkg::*;
#(
    parameter int XSR_CYC  = 8,
    parameter int MIN_NOPS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_idle,
    input  logic       xfer_active,
    input  logic [3:0] host_cmd,
    output logic       host_ready,
    input  logic       pd_req,
    output logic       pd_ack,
    input  logic       sr_req,
    output logic       sr_ack,
    input  logic       dpd_req,
    output logic       dpd_ack,
    input  logic       cs_req,
    output logic       cs_ack,
    output logic       init_req,
    input  logic       init_done,
    output logic       sdr_cke,
    output logic [3:0] sdr_cmd,
    output logic [2:0] mem_state
);

    localparam int N_LP = 4;

    typedef struct packed {
        ctl_e ctl;
        pin_s pins;
    } seq_s;

    seq_s     r_q, r_d;
    lp_kind_e grant;
    mstate_e  shadow_state;
    logic     shadow_illegal;
    logic     arb_en;
    logic     rdy_d;

    assign arb_en = (r_q.ctl == C_RUN) && (shadow_state == MS_NORMAL);

    lp_arb #(.N_LP(N_LP)) u_arb (
        .en          (arb_en),
        .banks_idle  (banks_idle),
        .xfer_active (xfer_active),
        .req_vec     ({pd_req, sr_req, dpd_req, cs_req}),
        .grant       (grant)
    );

    lp_shadow #(.XSR_CYC(XSR_CYC), .MIN_NOPS(MIN_NOPS)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (r_q.pins),
        .init_done (init_done),
        .state     (shadow_state),
        .illegal   (shadow_illegal)
    );

    always_comb begin
        r_d            = r_q;
        rdy_d          = 1'b0;
        r_d.pins.cke   = 1'b1;
        r_d.pins.cmd   = CMD_NOP;
        r_d.pins.idle  = banks_idle;
        r_d.pins.xfer  = xfer_active;
        case (r_q.ctl)
            C_RUN: begin
                if (arb_en) begin
                    case (grant)
                        LP_CS: begin
                            r_d.pins.cke = 1'b0;
                            r_d.ctl      = C_CS;
                        end
                        LP_DPD: begin
                            r_d.pins.cke = 1'b0;
                            r_d.pins.cmd = CMD_BST;
                            r_d.ctl      = C_DPD;
                        end
                        LP_SR: begin
                            r_d.pins.cke = 1'b0;
                            r_d.pins.cmd = CMD_AREF;
                            r_d.ctl      = C_SR;
                        end
                        LP_PD: begin
                            r_d.pins.cke = 1'b0;
                            r_d.ctl      = C_PD;
                        end
                        default: begin
                            r_d.pins.cmd = host_cmd;
                            rdy_d        = 1'b1;
                        end
                    endcase
                end
            end
            C_PD: begin
                if (pd_req) r_d.pins.cke = 1'b0;
                else        r_d.ctl      = C_WAIT;
            end
            C_SR: begin
                if (sr_req) r_d.pins.cke = 1'b0;
                else        r_d.ctl      = C_WAIT;
            end
            C_CS: begin
                if (cs_req) r_d.pins.cke = 1'b0;
                else        r_d.ctl      = C_WAIT;
            end
            C_DPD: begin
                if (dpd_req) r_d.pins.cke = 1'b0;
                else         r_d.ctl      = C_INIT;
            end
            C_WAIT: begin
                if (shadow_state == MS_NORMAL) r_d.ctl = C_RUN;
            end
            C_INIT: begin
                if (shadow_state == MS_UNINIT) begin
                    r_d.pins.cmd = host_cmd;
                    rdy_d        = 1'b1;
                end else if (shadow_state == MS_NORMAL) begin
                    r_d.ctl = C_RUN;
                end
            end
            default: r_d.ctl = C_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctl       <= C_RUN;
            r_q.pins.cke  <= 1'b1;
            r_q.pins.cmd  <= CMD_NOP;
            r_q.pins.idle <= 1'b0;
            r_q.pins.xfer <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ready = rdy_d;
    assign sdr_cke    = r_q.pins.cke;
    assign sdr_cmd    = r_q.pins.cmd;
    assign mem_state  = shadow_state;
    assign pd_ack     = (shadow_state == MS_PD);
    assign sr_ack     = (shadow_state == MS_SR) || (shadow_state == MS_SRX);
    assign dpd_ack    = (shadow_state == MS_DPD);
    assign cs_ack     = (shadow_state == MS_CSUSP);
    assign init_req   = (shadow_state == MS_UNINIT);

endmodule

// File: rtl/lp_cke_seq_chk.sv
module lp_cke_seq_chk
    import lp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       banks_idle,
    input logic [3:0] host_cmd,
    input logic       host_ready,
    input logic       sdr_cke,
    input logic [3:0] sdr_cmd,
    input logic [2:0] mem_state,
    input logic       pd_ack,
    input logic       sr_ack,
    input logic       dpd_ack,
    input logic       cs_ack,
    input logic       init_req,
    input logic       illegal
);

    AST_PINS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal);                                                          // R13

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> (sdr_cke && sdr_cmd == $past(host_cmd)));            // R2

    AST_LOWPWR_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_state inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) |-> !host_ready); // R6

    AST_ENTRY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdr_cke) && (sdr_cmd == CMD_AREF || sdr_cmd == CMD_BST))
            |-> $past(banks_idle));                                         // R12

    AST_SRX_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_state == 3'd5) |-> (sdr_cke && (sdr_cmd[3] || sdr_cmd == CMD_NOP))); // R8

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_ack, sr_ack, dpd_ack, cs_ack, init_req}));             // R11

endmodule

bind lp_cke_seq lp_cke_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .host_cmd   (host_cmd),
    .host_ready (host_ready),
    .sdr_cke    (sdr_cke),
    .sdr_cmd    (sdr_cmd),
    .mem_state  (mem_state),
    .pd_ack     (pd_ack),
    .sr_ack     (sr_ack),
    .dpd_ack    (dpd_ack),
    .cs_ack     (cs_ack),
    .init_req   (init_req),
    .illegal    (shadow_illegal)
);

// File: tb/lp_cke_seq_bench.sv
`timescale 1ns/1ps
module lp_cke_seq_bench;

    localparam int XSR  = 8;
    localparam int MINN = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       banks_idle = 1'b1, xfer_active = 1'b0;
    logic [3:0] host_cmd = 4'b0111;
    logic       host_ready;
    logic       pd_req = 0, sr_req = 0, dpd_req = 0, cs_req = 0, init_done = 0;
    logic       pd_ack, sr_ack, dpd_ack, cs_ack, init_req;
    logic       sdr_cke;
    logic [3:0] sdr_cmd;
    logic [2:0] mem_state;

    always #2.5 clk = ~clk;

    lp_cke_seq #(.XSR_CYC(XSR), .MIN_NOPS(MINN)) u_lp_cke_seq (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .xfer_active(xfer_active),
        .host_cmd(host_cmd), .host_ready(host_ready),
        .pd_req(pd_req), .pd_ack(pd_ack), .sr_req(sr_req), .sr_ack(sr_ack),
        .dpd_req(dpd_req), .dpd_ack(dpd_ack), .cs_req(cs_req), .cs_ack(cs_ack),
        .init_req(init_req), .init_done(init_done),
        .sdr_cke(sdr_cke), .sdr_cmd(sdr_cmd), .mem_state(mem_state)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pin-level memory model
    int   m_state = 0;
    bit   m_prev = 1;
    int   m_edges = 0, m_nops = 0;
    bit   pend = 0;
    bit   p_cke, p_idle, p_xfer, p_init;
    logic [3:0] p_cmd;

    task automatic model_apply();
        bit q, ill;
        q   = p_cmd[3] || (p_cmd == 4'b0111);
        ill = 0;
        if (m_state == 0) begin
            if (!m_prev) ill = 1;
            else if (!p_cke) begin
                if (q && p_xfer) m_state = 4;
                else if (q && p_idle) m_state = 1;
                else if (p_cmd == 4'b0001 && p_idle && !p_xfer) m_state = 2;
                else if (p_cmd == 4'b0110 && p_idle && !p_xfer) m_state = 3;
                else ill = 1;
            end
        end else if (m_state >= 1 && m_state <= 4) begin
            if (p_cke) begin
                if (!q) ill = 1;
                else if (m_state == 2) begin m_state = 5; m_edges = 0; m_nops = 0; end
                else if (m_state == 3) m_state = 6;
                else m_state = 0;
            end
        end else if (m_state == 5) begin
            if (!p_cke || !q) ill = 1;
            else if (m_edges >= XSR && m_nops >= MINN) m_state = 0;
            else begin
                m_edges++;
                if (p_cmd == 4'b0111) m_nops++;
            end
        end else begin
            if (!p_cke) ill = 1;
            else if (p_init) m_state = 0;
        end
        m_prev = p_cke;
        chk(!ill, "R13 illegal pin combination", 1, 0);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_prev = 1; pend = 0;
        end else if (!done) begin
            if (pend) model_apply();
            chk(int'(mem_state) == m_state, "R13 shadow state", mem_state, m_state);
            chk(pd_ack == (m_state == 1) && sr_ack == (m_state == 2 || m_state == 5) &&
                dpd_ack == (m_state == 3) && cs_ack == (m_state == 4) &&
                init_req == (m_state == 6), "R11 acks follow state",
                {pd_ack, sr_ack, dpd_ack, cs_ack, init_req}, m_state);
            p_cke = sdr_cke; p_cmd = sdr_cmd; p_idle = banks_idle;
            p_xfer = xfer_active; p_init = init_done; pend = 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sdr_cke == 1 && sdr_cmd == 4'b0111, "R1 reset pins", {sdr_cke, sdr_cmd}, 5'b10111);
        chk(mem_state == 0 && !pd_ack && !sr_ack && !dpd_ack && !cs_ack && !init_req,
            "R1 reset state", mem_state, 0);

        // R2 pass-through
        tick(0); #1;
        host_cmd = 4'b0011;
        chk(host_ready == 1, "R2 ready", host_ready, 1);
        tick(1);
        chk(sdr_cmd == 4'b0011 && sdr_cke, "R2 passthrough", sdr_cmd, 4'b0011);
        host_cmd = 4'b0111;
        tick(2);

        // R3 power-down entry, R6 hold
        pd_req = 1;
        tick(1);
        chk(sdr_cke == 0 && sdr_cmd == 4'b0111, "R3 entry pins", {sdr_cke, sdr_cmd}, 5'b00111);
        tick(1);
        chk(pd_ack == 1 && mem_state == 1, "R3 pd_ack", mem_state, 1);
        host_cmd = 4'b0011;
        tick(3);
        chk(sdr_cke == 0 && sdr_cmd == 4'b0111 && !host_ready, "R6 host ignored",
            {sdr_cke, sdr_cmd}, 5'b00111);
        host_cmd = 4'b0111;
        // R7 exit
        pd_req = 0;
        n = 0;
        do begin tick(1); n++; end while (!host_ready && n < 50);
        chk(n == 3, "R7 ready after pd exit", n, 3);
        chk(mem_state == 0 && sdr_cke, "R7 normal", mem_state, 0);

        // R4 self refresh, R8 exit window
        sr_req = 1;
        tick(1);
        chk(sdr_cke == 0 && sdr_cmd == 4'b0001, "R4 entry pins", {sdr_cke, sdr_cmd}, 5'b00001);
        tick(1);
        chk(sr_ack && mem_state == 2, "R4 sr_ack", mem_state, 2);
        tick(3);
        sr_req = 0;
        n = 0;
        do begin tick(1); n++; end while (!host_ready && n < 100);
        chk(n == XSR + 4, "R8 ready after sr exit", n, XSR + 4);
        chk(!sr_ack, "R8 ack cleared", sr_ack, 0);

        // R5 deep power-down wins over self refresh (R11)
        dpd_req = 1; sr_req = 1;
        tick(1);
        chk(sdr_cke == 0 && sdr_cmd == 4'b0110, "R5 entry pins", {sdr_cke, sdr_cmd}, 5'b00110);
        tick(1);
        chk(dpd_ack && !sr_ack && mem_state == 3, "R11 dpd over sr", mem_state, 3);
        tick(2);
        chk(!host_ready && !sdr_cke, "R6 dpd hold", sdr_cke, 0);
        dpd_req = 0; sr_req = 0;
        // R9 re-init
        tick(2);
        chk(init_req && mem_state == 6, "R9 init_req", mem_state, 6);
        chk(host_ready == 1, "R9 host during init", host_ready, 1);
        host_cmd = 4'b0010;
        tick(1);
        chk(sdr_cmd == 4'b0010, "R9 init passthrough", sdr_cmd, 4'b0010);
        host_cmd = 4'b0111;
        init_done = 1;
        tick(1);
        init_done = 0;
        chk(!init_req && mem_state == 0, "R9 init finished", mem_state, 0);
        tick(3);

        // R11 sr over pd, pd held pending
        sr_req = 1; pd_req = 1;
        tick(2);
        chk(sr_ack && !pd_ack, "R11 sr over pd", {sr_ack, pd_ack}, 2);
        sr_req = 0;
        tick(XSR + 8);
        chk(pd_ack && !sr_ack, "R11 pending pd granted", {sr_ack, pd_ack}, 1);
        pd_req = 0;
        tick(5);

        // R12 held while banks open
        banks_idle = 0; pd_req = 1;
        tick(6);
        chk(!pd_ack && sdr_cke && host_ready, "R12 held while busy", pd_ack, 0);
        banks_idle = 1;
        tick(2);
        chk(pd_ack == 1, "R12 granted when idle", pd_ack, 1);
        pd_req = 0;
        tick(5);

        // R10 clock suspend during a transfer, pd held
        banks_idle = 0; xfer_active = 1; cs_req = 1; pd_req = 1;
        tick(1);
        chk(sdr_cke == 0 && sdr_cmd == 4'b0111, "R10 entry pins", {sdr_cke, sdr_cmd}, 5'b00111);
        tick(1);
        chk(cs_ack && !pd_ack && mem_state == 4, "R10 cs_ack", mem_state, 4);
        cs_req = 0;
        tick(1);
        chk(sdr_cke == 1, "R10 cke raised", sdr_cke, 1);
        tick(1);
        chk(!cs_ack && mem_state == 0, "R10 resumed", mem_state, 0);
        tick(4);
        chk(!pd_ack && sdr_cke, "R12 no pd during transfer", pd_ack, 0);
        pd_req = 0; xfer_active = 0; banks_idle = 1;
        tick(5);
        report();
    end

endmodule